// File: doc/BRIEF.md
# DMA Channel Control Registers

This block is the software-visible control and status face of a single DMA channel. It holds four 32-bit words on a simple register bus: a control/status word, a transfer address counter and two general-purpose words. The control word carries a fixed version stamp, an interrupt-pending flag, an interrupt enable, a peripheral reset request, a drain request and a channel enable. The block turns these into three sideband outputs toward the attached peripheral and the interrupt controller.

The peripheral raises and lowers its interrupt line. The block records that activity as a pending flag and passes it to the system interrupt only while software has enabled it. After each transfer the peripheral pulses a done strobe with a byte count, and the block adds that count to the address word. Software loads the address word before it starts a channel. Each such load also sets a sticky loaded flag in the control word.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset, word 0 reads 0xA0000000 and words 1 to 3 read 0. The irq_o, periph_rst_o and dma_en_o outputs are all low.
- R2: Bits under mask 0xFE000007 of word 0 cannot be changed by software. A write to word 0 stores (old & 0xFE000007) | (value & 0x01FFFFF8) | 0xA0000000, where value is the written data after the R6 rewrite.
- R3: Bit 0 of word 0 is the pending flag. A low-to-high change on periph_irq_i sets it at the next edge, and a high-to-low change clears it.
- R4: irq_o is high exactly while bit 0 and bit 4 (interrupt enable) of word 0 are both set. A write to bit 4 takes effect on irq_o in the cycle after the write.
- R5: A word 0 write with bit 7 set makes periph_rst_o high for exactly the following cycle. The written value is stored unchanged apart from the R2 masking.
- R6: In a word 0 write with bit 7 clear, a set bit 6 is stored as 0. A word 0 write of exactly 0 is stored as bit 6 alone (0x40).
- R7: dma_en_o goes high after a word 0 write that sets bit 9 while it was clear. It goes low after a write that clears bit 9 while it was set. It otherwise holds.
- R8: A write to word 1 stores the data and sets bit 26 of word 0. Bit 26 then stays set until reset.
- R9: A xfer_done_i pulse adds the zero-extended xfer_len_i to word 1, modulo 2^32.
- R10: Words 2 and 3 store written data and have no other effect.
- R11: A write is accepted only when be_i is 4'hF and addr_i[1:0] is 0. Other writes change nothing. Reads have no side effects, and addr_i[3:2] selects the word.
- R12: When a periph_irq_i edge and a word 0 write fall in the same cycle, the edge decides the stored pending flag.
- R13: When a word 1 write and xfer_done_i fall in the same cycle, the written value is stored and the count is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 4 | Byte address; bits [3:2] select the word |
| be_i | input | 4 | Byte enables; only 4'hF is accepted for writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data of the addressed word |
| periph_irq_i | input | 1 | Interrupt level from the peripheral |
| xfer_done_i | input | 1 | One-cycle strobe per completed transfer |
| xfer_len_i | input | 16 | Byte count of the completed transfer |
| irq_o | output | 1 | Gated interrupt to the system |
| periph_rst_o | output | 1 | One-cycle reset pulse to the peripheral |
| dma_en_o | output | 1 | Channel enable level to the peripheral |

## Verification
Directed writes to the control word include all ones, zero, a drain-only value and a drain-plus-reset value. Together these separate the drain rewrite from the reset exemption and from the read-only masking. Interrupt edges are placed with the enable set, with it clear, and in the same cycle as a control write, which separates gating from latching and shows the priority. The address counter is tried with a wrap past 2^32 and with a load colliding with a transfer strobe. Long random runs of mixed accesses, partial strobes, misaligned addresses, interrupt toggles and transfers are then compared word by word against a bench model.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  parameter int unsigned WORD_W      = 32;
  parameter logic [31:0] CTL_VERSION = 32'hA000_0000;
  parameter logic [31:0] CTL_RO_MASK = 32'hFE00_0007;
  parameter int unsigned PEND_BIT    = 0;
  parameter int unsigned IEN_BIT     = 4;
  parameter int unsigned DRAIN_BIT   = 6;
  parameter int unsigned SRST_BIT    = 7;
  parameter int unsigned EN_BIT      = 9;
  parameter int unsigned LOADED_BIT  = 26;
  parameter int unsigned IDX_CTL     = 0;
  parameter int unsigned IDX_ADDR    = 1;
  parameter int unsigned IDX_SCR     = 2;

  // drain/zero rewrite applied to a control write before masking
  function automatic logic [31:0] ctl_rewrite(input logic [31:0] v);
    logic [31:0] r;
    r = v;
    if (!v[SRST_BIT]) begin
      if (v[DRAIN_BIT]) r[DRAIN_BIT] = 1'b0;
      else if (v == '0) r[DRAIN_BIT] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/dma_ctl_csr.sv
module dma_ctl_csr
  import dma_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              load_set_i,
  input  logic              periph_irq_i,
  output logic [WORD_W-1:0] ctl_o,
  output logic              irq_o,
  output logic              periph_rst_o,
  output logic              dma_en_o
);
  logic [WORD_W-1:0] ctl_q, ctl_d, base, wv;
  logic irq_prev_q, rise, fall, pend_d;
  logic en_q, en_d, rst_q;

  always_comb begin
    rise   = periph_irq_i & ~irq_prev_q;
    fall   = ~periph_irq_i & irq_prev_q;
    pend_d = rise ? 1'b1 : (fall ? 1'b0 : ctl_q[PEND_BIT]);
    wv     = ctl_rewrite(wdata_i);
    base   = ctl_q;
    base[PEND_BIT] = pend_d;
    if (load_set_i) base[LOADED_BIT] = 1'b1;
    ctl_d = wr_i ? ((base & CTL_RO_MASK) | (wv & ~CTL_RO_MASK) | CTL_VERSION) : base;
    en_d = en_q;
    if (wr_i) begin
      if (wv[EN_BIT] && !ctl_q[EN_BIT]) en_d = 1'b1;
      else if (!wv[EN_BIT] && ctl_q[EN_BIT]) en_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q      <= CTL_VERSION;
      irq_prev_q <= 1'b0;
      en_q       <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      ctl_q      <= ctl_d;
      irq_prev_q <= periph_irq_i;
      en_q       <= en_d;
      rst_q      <= wr_i & wdata_i[SRST_BIT];
    end
  end

  assign ctl_o        = ctl_q;
  assign irq_o        = ctl_q[PEND_BIT] & ctl_q[IEN_BIT];
  assign periph_rst_o = rst_q;
  assign dma_en_o     = en_q;

  // R3
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(periph_irq_i) |=> ctl_q[PEND_BIT]);
  // R12
  pend_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && $fell(periph_irq_i)) |=> !ctl_q[PEND_BIT]);
  // R5
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periph_rst_o |-> $past(wr_i && wdata_i[SRST_BIT]));
  // R7
  en_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_en_o) |-> $past(wr_i && wdata_i[EN_BIT]));
  // R8
  loaded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_set_i |=> ctl_q[LOADED_BIT]);
  // R2
  version_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q[31:29] == 3'b101) && (ctl_q[28:27] == 2'b00) && !ctl_q[25]);
endmodule

// File: rtl/dma_ctl_addr.sv
module dma_ctl_addr
  import dma_ctl_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              xfer_done_i,
  input  logic [LEN_W-1:0]  xfer_len_i,
  output logic [WORD_W-1:0] addr_o
);
  localparam int unsigned PAD_W = WORD_W - LEN_W;

  logic [WORD_W-1:0] addr_q, len_ext;

  assign len_ext = {{PAD_W{1'b0}}, xfer_len_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          addr_q <= '0;
    else if (wr_i)        addr_q <= wdata_i;
    else if (xfer_done_i) addr_q <= addr_q + len_ext;
  end

  assign addr_o = addr_q;

  // R9
  advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_i && !wr_i) |=> addr_q == $past(addr_q) + $past(len_ext));
  // R13
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> addr_q == $past(wdata_i));
endmodule

// File: rtl/dma_ctl_scratch.sv
module dma_ctl_scratch
  import dma_ctl_pkg::*;
#(
  parameter int unsigned NUM = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM-1:0]            wr_i,
  input  logic [WORD_W-1:0]         wdata_i,
  output logic [NUM-1:0][WORD_W-1:0] q_o
);
  for (genvar k = 0; k < NUM; k++) begin : g_word
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= '0;
      else if (wr_i[k]) q <= wdata_i;
    end
    assign q_o[k] = q;
  end

  // R10
  one_hot_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(wr_i));
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_ctl_pkg::*;
#(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned NUM_WORDS = 4
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 req_i,
  input  logic                                 we_i,
  input  logic [$clog2(NUM_WORDS)+1:0]         addr_i,
  input  logic [3:0]                           be_i,
  input  logic [WORD_W-1:0]                    wdata_i,
  output logic [WORD_W-1:0]                    rdata_o,
  input  logic                                 periph_irq_i,
  input  logic                                 xfer_done_i,
  input  logic [LEN_W-1:0]                     xfer_len_i,
  output logic                                 irq_o,
  output logic                                 periph_rst_o,
  output logic                                 dma_en_o
);
  localparam int unsigned IDX_W  = $clog2(NUM_WORDS);
  localparam int unsigned ADDR_W = IDX_W + 2;
  localparam int unsigned NUM_SCR = NUM_WORDS - IDX_SCR;

  logic                               acc;
  logic [IDX_W-1:0]                   idx;
  logic                               wr_ctl, wr_adr;
  logic [NUM_SCR-1:0]                 wr_scr;
  logic [WORD_W-1:0]                  ctl_w, adr_w;
  logic [NUM_SCR-1:0][WORD_W-1:0]     scr_q;
  logic [NUM_WORDS-1:0][WORD_W-1:0]   words;

  assign acc    = req_i & we_i & (be_i == 4'hF) & (addr_i[1:0] == 2'b00);
  assign idx    = addr_i[ADDR_W-1:2];
  assign wr_ctl = acc && (idx == IDX_W'(IDX_CTL));
  assign wr_adr = acc && (idx == IDX_W'(IDX_ADDR));

  for (genvar k = 0; k < NUM_SCR; k++) begin : g_scr_wr
    assign wr_scr[k] = acc && (idx == IDX_W'(k + IDX_SCR));
    assign words[k + IDX_SCR] = scr_q[k];
  end

  dma_ctl_csr u_csr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_ctl),
    .wdata_i      (wdata_i),
    .load_set_i   (wr_adr),
    .periph_irq_i (periph_irq_i),
    .ctl_o        (ctl_w),
    .irq_o        (irq_o),
    .periph_rst_o (periph_rst_o),
    .dma_en_o     (dma_en_o)
  );

  dma_ctl_addr #(.LEN_W(LEN_W)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_adr),
    .wdata_i     (wdata_i),
    .xfer_done_i (xfer_done_i),
    .xfer_len_i  (xfer_len_i),
    .addr_o      (adr_w)
  );

  dma_ctl_scratch #(.NUM(NUM_SCR)) u_scr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_scr),
    .wdata_i (wdata_i),
    .q_o     (scr_q)
  );

  assign words[IDX_CTL]  = ctl_w;
  assign words[IDX_ADDR] = adr_w;
  assign rdata_o         = words[idx];

  // R11
  partial_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (be_i != 4'hF)) |=> $stable(scr_q));
endmodule

// File: tb/dma_ctl_regs_bench.sv
`timescale 1ns/1ps
module dma_ctl_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req, we, pirq, xd, irq, prst, en;
  logic [3:0]  addr, be;
  logic [31:0] wdata, rdata;
  logic [15:0] len;

  dma_ctl_regs u_dma_ctl_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .be_i(be),
    .wdata_i(wdata), .rdata_o(rdata), .periph_irq_i(pirq), .xfer_done_i(xd),
    .xfer_len_i(len), .irq_o(irq), .periph_rst_o(prst), .dma_en_o(en)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        b_req = 0, b_we = 0, b_pirq = 0, b_xd = 0;
  logic [3:0]  b_addr = 0, b_be = 4'hF;
  logic [31:0] b_wdata = 0;
  logic [15:0] b_len = 0;

  logic [31:0] m_w [4];
  logic        m_prev, m_rst, m_en;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_rewrite(input logic [31:0] v);
    if (v[7]) return v;
    if (v[6]) return v & ~32'h40;
    if (v == 0) return 32'h40;
    return v;
  endfunction

  task automatic m_update();
    logic        acc;
    logic [1:0]  s;
    logic [31:0] n0, v;
    acc = b_req && b_we && b_be == 4'hF && b_addr[1:0] == 2'b00;
    s = b_addr[3:2];
    n0 = m_w[0];
    if (b_pirq && !m_prev) n0[0] = 1'b1;
    else if (!b_pirq && m_prev) n0[0] = 1'b0;
    m_prev = b_pirq;
    m_rst = 1'b0;
    if (acc && s == 1) begin n0[26] = 1'b1; m_w[1] = b_wdata; end
    else if (b_xd) m_w[1] = m_w[1] + {16'h0, b_len};
    if (acc && s == 0) begin
      v = f_rewrite(b_wdata);
      if (v[9] && !m_w[0][9]) m_en = 1'b1;
      else if (!v[9] && m_w[0][9]) m_en = 1'b0;
      m_rst = b_wdata[7];
      n0 = (n0 & 32'hFE000007) | (v & 32'h01FFFFF8) | 32'hA0000000;
    end
    if (acc && s >= 2) m_w[s] = b_wdata;
    m_w[0] = n0;
  endtask

  // called at a negedge: compare outputs, apply inputs, cross one posedge
  task automatic tick();
    string t;
    case (addr[3:2])
      2'd0: t = "R2";
      2'd1: t = "R8";
      default: t = "R10";
    endcase
    chk(t, rdata, m_w[addr[3:2]]);
    chk("R4", {31'h0, irq}, {31'h0, m_w[0][0] & m_w[0][4]});
    chk("R5", {31'h0, prst}, {31'h0, m_rst});
    chk("R7", {31'h0, en}, {31'h0, m_en});
    req = b_req; we = b_we; addr = b_addr; be = b_be; wdata = b_wdata;
    pirq = b_pirq; xd = b_xd; len = b_len;
    @(posedge clk);
    m_update();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    b_req = 1; b_we = 1; b_addr = a; b_wdata = d; b_be = 4'hF;
    tick();
    b_req = 0; b_we = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    b_req = 1; b_we = 0; b_addr = a;
    tick();
    b_req = 0;
  endtask

  initial begin
    req = 0; we = 0; addr = 0; be = 4'hF; wdata = 0; pirq = 0; xd = 0; len = 0;
    m_w[0] = 32'hA0000000; m_w[1] = 0; m_w[2] = 0; m_w[3] = 0;
    m_prev = 0; m_rst = 0; m_en = 0;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", {29'h0, irq, prst, en}, 32'h0);
    rd(4'h0); chk("R1", rdata, 32'hA0000000);
    rd(4'h4); chk("R1", rdata, 32'h0);
    rd(4'h8); chk("R1", rdata, 32'h0);
    rd(4'hC); chk("R1", rdata, 32'h0);

    // R2 masking, R5 pulse, R7 enable rise
    wr(4'h0, 32'hFFFFFFFF);
    chk("R2", rdata, 32'hA1FFFFF8);
    chk("R5", {31'h0, prst}, 32'h1);
    chk("R7", {31'h0, en}, 32'h1);
    rd(4'h0);
    chk("R5", {31'h0, prst}, 32'h0);

    // R6 drain rewrite, R7 enable fall
    wr(4'h0, 32'h0);
    chk("R6", rdata, 32'hA0000040);
    chk("R7", {31'h0, en}, 32'h0);
    wr(4'h0, 32'h40);
    chk("R6", rdata, 32'hA0000000);
    wr(4'h0, 32'hC0);
    chk("R6", rdata, 32'hA00000C0);
    chk("R5", {31'h0, prst}, 32'h1);

    // R3 / R4 pending and gating
    wr(4'h0, 32'h10);
    chk("R4", {31'h0, irq}, 32'h0);
    b_pirq = 1; rd(4'h0);
    chk("R3", rdata, 32'hA0000011);
    chk("R4", {31'h0, irq}, 32'h1);
    wr(4'h0, 32'h200);
    chk("R4", {31'h0, irq}, 32'h0);
    chk("R3", rdata, 32'hA0000201);
    b_pirq = 0; rd(4'h0);
    chk("R3", rdata, 32'hA0000200);

    // R12 edge in same cycle as control write
    b_pirq = 1; wr(4'h0, 32'h10);
    chk("R12", rdata, 32'hA0000011);
    chk("R12", {31'h0, irq}, 32'h1);

    // R8 address load sets loaded flag
    wr(4'h4, 32'h0000_1000);
    chk("R8", rdata, 32'h0000_1000);
    rd(4'h0);
    chk("R8", rdata, 32'hA4000011);

    // R9 advance and wrap
    b_xd = 1; b_len = 16'h0024; rd(4'h4); b_xd = 0;
    rd(4'h4); chk("R9", rdata, 32'h0000_1024);
    wr(4'h4, 32'hFFFF_FFF0);
    b_xd = 1; b_len = 16'h0020; rd(4'h4); b_xd = 0;
    rd(4'h4); chk("R9", rdata, 32'h0000_0010);

    // R13 load beats transfer
    b_xd = 1; b_len = 16'h0008; wr(4'h4, 32'h0000_0500); b_xd = 0;
    rd(4'h4); chk("R13", rdata, 32'h0000_0500);

    // R10 plain storage
    wr(4'h8, 32'hDEAD_BEEF);
    wr(4'hC, 32'h1234_5678);
    rd(4'h8); chk("R10", rdata, 32'hDEAD_BEEF);
    rd(4'hC); chk("R10", rdata, 32'h1234_5678);

    // R11 partial strobes and misaligned writes ignored
    b_req = 1; b_we = 1; b_addr = 4'h8; b_be = 4'h7; b_wdata = 32'h0; tick();
    b_be = 4'hF; b_addr = 4'h9; b_wdata = 32'h0; tick();
    b_req = 0; b_we = 0; b_addr = 4'h8;
    rd(4'h8); chk("R11", rdata, 32'hDEAD_BEEF);
    rd(4'h0); chk("R11", rdata, 32'hA4000011);

    // constrained random mix, checked against the model in tick()
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      b_req  = (r < 7);
      b_we   = (r < 5);
      b_addr = {$urandom_range(0, 3)[1:0], ($urandom_range(0, 7) == 0) ? 2'b01 : 2'b00};
      b_be   = ($urandom_range(0, 7) == 0) ? 4'h3 : 4'hF;
      case ($urandom_range(0, 5))
        0: b_wdata = 32'h0;
        1: b_wdata = 32'h40;
        2: b_wdata = 32'h210;
        default: b_wdata = $urandom;
      endcase
      if ($urandom_range(0, 3) == 0) b_pirq = ~b_pirq;
      b_xd  = ($urandom_range(0, 2) == 0);
      b_len = $urandom;
      tick();
    end
    b_req = 0; b_we = 0; b_xd = 0; b_pirq = 0;
    tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule